// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers up to 32 peripheral request lines into one interrupt output for a processor. Each line is captured into a sticky status bit. A build parameter fixes, per line, whether the line is captured on a rising transition or on a high level. Software cannot change that choice. A captured bit stays set until software acknowledges it.

The status bits are gated by per-line enable bits and by a two-bit master enable. A fixed-priority encoder reports the lowest-numbered request that is both captured and enabled.

Software reaches the block through a simple word-addressed register port. Enable bits can be changed wholesale through the enable register. They can also be changed atomically through a set-enable register and a clear-enable register, so no read-modify-write sequence is needed. The request inputs are assumed to be synchronous to the block clock.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the registers read as follows. Status, pending, enable and master enable read zero. The vector reads 0xFFFFFFFF. `irq_out` is low.
- R2: The register is selected by byte address bits [4:2]:
  - 0x00 status
  - 0x04 pending
  - 0x08 enable (read/write)
  - 0x0C acknowledge
  - 0x10 set-enable
  - 0x14 clear-enable
  - 0x18 vector
  - 0x1C master enable (bits [1:0])

  A read presented with `reg_rd` appears on `reg_rdata` after the next clock edge.
- R3: A line whose bit in `SENSE_EDGE` is 1 sets its status bit when its input is high and was low at the previous clock edge. Holding the input high after an acknowledge does not set the bit again.
- R4: A line whose bit in `SENSE_EDGE` is 0 sets its status bit on every clock edge at which its input is high. An acknowledge in the same cycle does not clear it. The bit stays set after the input falls, until it is acknowledged.
- R5: Writing the acknowledge register clears the status bits where the written word has ones. All other status bits are left unchanged.
- R6: Writing the set-enable register sets the enable bits where the written word has ones. All other enable bits are left unchanged.
- R7: Writing the clear-enable register clears the enable bits where the written word has ones. All other enable bits are left unchanged.
- R8: The pending register reads as status AND enable.
- R9: The vector register reads the index of the lowest-numbered pending bit, zero-extended to 32 bits. It reads 0xFFFFFFFF when no bit is pending.
- R10: `irq_out` is high when any pending bit is set and the master enable equals binary 11. It follows the register state with one clock of delay.
- R11: The following accesses have no effect or read as zero:
  - Writes to the status, pending and vector registers change no state.
  - Reads of the acknowledge, set-enable and clear-enable registers return zero.
  - Register bits at or above `NUM_SRC` read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Peripheral request lines |
| reg_addr | input | 5 | Byte address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest condition to reach is a particular combination of captured status and enable, because status can only be built up from the request lines themselves. Edge lines and level lines capture differently, yet a one-cycle pulse on every selected line leaves exactly the chosen status pattern latched in both kinds. The bench therefore sweeps all 256 status patterns of an eight-line configuration this way and pairs each pattern with a computed enable mask. Against each pair it checks pending, vector and `irq_out`. Held inputs across an acknowledge are driven separately, to separate edge capture from level capture.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_STAT   = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENAB   = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VEC    = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int                   NUM_SRC    = 32,
  parameter logic [NUM_SRC-1:0]   SENSE_EDGE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] status_q
);
  localparam logic [NUM_SRC-1:0] LEVEL_LINES = ~SENSE_EDGE;

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    if (SENSE_EDGE[g]) begin : g_edge
      assign hit[g] = irq_in[g] & ~prev_q[g];
    end else begin : g_level
      assign hit[g] = irq_in[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= irq_in;
      status_q <= (status_q & ~ack_mask) | hit;
    end
  end

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(irq_in & LEVEL_LINES)) == $past(irq_in & LEVEL_LINES)));

  // R5
  clear_by_ack_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(ack_mask)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int                 NUM_SRC    = 32,
  parameter logic [NUM_SRC-1:0] SENSE_EDGE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   irq_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 reg_rd,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_out
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wdata_n;
  logic [NUM_SRC-1:0] ack_mask;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] pending;
  logic [1:0]         master_q;
  logic               vec_any;
  logic [IDX_W-1:0]   vec_idx;
  logic [DATA_W-1:0]  rd_mux;

  assign sel      = reg_sel_e'(reg_addr[4:2]);
  assign wdata_n  = reg_wdata[NUM_SRC-1:0];
  assign ack_mask = (reg_wr && sel == SEL_ACK) ? wdata_n : '0;
  assign pending  = status_q & enable_q;

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_SRC-1:0] = v;
    return r;
  endfunction

  irq_capture #(.NUM_SRC(NUM_SRC), .SENSE_EDGE(SENSE_EDGE)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .ack_mask (ack_mask),
    .status_q (status_q)
  );

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .req (pending),
    .any (vec_any),
    .idx (vec_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      master_q <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_ENAB:   enable_q <= wdata_n;
        SEL_SETEN:  enable_q <= enable_q | wdata_n;
        SEL_CLREN:  enable_q <= enable_q & ~wdata_n;
        SEL_MASTER: master_q <= reg_wdata[1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_STAT:   rd_mux = widen(status_q);
      SEL_PEND:   rd_mux = widen(pending);
      SEL_ENAB:   rd_mux = widen(enable_q);
      SEL_VEC:    rd_mux = vec_any ? DATA_W'(vec_idx) : '1;
      SEL_MASTER: rd_mux = {{(DATA_W-2){1'b0}}, master_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq_out <= (|pending) && (master_q == 2'b11);
    end
  end

  // R6
  set_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_SETEN) |=>
      ((enable_q & $past(wdata_n)) == $past(wdata_n)) &&
      ((enable_q & ~$past(wdata_n)) == ($past(enable_q) & ~$past(wdata_n))));

  // R7
  clr_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_CLREN) |=>
      ((enable_q & $past(wdata_n)) == '0) &&
      ((enable_q & ~$past(wdata_n)) == ($past(enable_q) & ~$past(wdata_n))));

  // R9
  vec_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    vec_any |-> (pending[vec_idx] && ((pending & ~({NUM_SRC{1'b1}} << vec_idx)) == '0)));

  // R10
  out_master_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(master_q) == 2'b11 && $past(status_q & enable_q) != '0));

  // R11
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (sel == SEL_ACK || sel == SEL_SETEN || sel == SEL_CLREN)) |=> (reg_rdata == '0));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int N = 8;
  localparam logic [N-1:0] EDGE = 8'b0000_1111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_ENAB = 5'h08, A_ACK = 5'h0C,
                         A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MST = 5'h1C;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .SENSE_EDGE(EDGE)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
  endtask

  function automatic logic [31:0] low_vec(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R2 map, R11 zero reads
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd(A_STAT, d); check("R1 status", d, 32'h0);
    rd(A_PEND, d); check("R1 pending", d, 32'h0);
    rd(A_ENAB, d); check("R1 enable", d, 32'h0);
    rd(A_VEC, d);  check("R1 vector", d, 32'hFFFF_FFFF);
    rd(A_MST, d);  check("R1 master", d, 32'h0);
    // R6 R7 atomic enable updates, R11 upper bits zero
    wr(A_ENAB, 32'hFFFF_FF0F); rd(A_ENAB, d); check("R11 upper bits", d, 32'h0F);
    wr(A_SET, 32'h30); rd(A_ENAB, d); check("R6 set-enable", d, 32'h3F);
    wr(A_CLR, 32'h05); rd(A_ENAB, d); check("R7 clear-enable", d, 32'h3A);
    rd(A_SET, d); check("R11 set read", d, 32'h0);
    rd(A_CLR, d); check("R11 clr read", d, 32'h0);
    rd(A_ACK, d); check("R11 ack read", d, 32'h0);
    // R11 ignored writes
    wr(A_STAT, 32'hFF); wr(A_PEND, 32'hFF); wr(A_VEC, 32'h3);
    rd(A_STAT, d); check("R11 status write ignored", d, 32'h0);
    rd(A_VEC, d); check("R11 vector write ignored", d, 32'hFFFF_FFFF);
    // R3 edge line held across ack
    @(negedge clk); irq_in = 8'h01;
    rd(A_STAT, d); check("R3 edge capture", d, 32'h01);
    wr(A_ACK, 32'h01); rd(A_STAT, d); check("R3 held edge not re-set", d, 32'h0);
    @(negedge clk); irq_in = '0;
    @(negedge clk); irq_in = 8'h01;
    rd(A_STAT, d); check("R3 new edge", d, 32'h01);
    @(negedge clk); irq_in = '0;
    wr(A_ACK, 32'hFF);
    // R4 level line held across ack
    @(negedge clk); irq_in = 8'h10;
    wr(A_ACK, 32'h10); rd(A_STAT, d); check("R4 level survives ack", d, 32'h10);
    @(negedge clk); irq_in = '0;
    rd(A_STAT, d); check("R4 level sticky", d, 32'h10);
    wr(A_ACK, 32'h10); rd(A_STAT, d); check("R4 level cleared", d, 32'h0);
    // R5 partial acknowledge
    pulse(8'hFF);
    wr(A_ACK, 32'h0F); rd(A_STAT, d); check("R5 partial ack", d, 32'hF0);
    wr(A_ACK, 32'hFFFF_FFFF); rd(A_STAT, d); check("R5 ack all", d, 32'h0);
    // R10 master enable gating
    pulse(8'h20); wr(A_ENAB, 32'hFF);
    wr(A_MST, 32'h1); rd(A_MST, d); check("R2 master read", d, 32'h1);
    check("R10 master 01 blocks", {31'b0, irq_out}, 32'h0);
    wr(A_MST, 32'h2); rd(A_MST, d);
    check("R10 master 10 blocks", {31'b0, irq_out}, 32'h0);
    wr(A_MST, 32'h3); rd(A_MST, d);
    check("R10 master 11 passes", {31'b0, irq_out}, 32'h1);
    wr(A_ACK, 32'hFF); rd(A_STAT, d);
    check("R10 drops after ack", {31'b0, irq_out}, 32'h0);
    // R8 R9 R10 sweep of every status pattern
    for (int p = 0; p < 256; p++) begin
      logic [N-1:0] e;
      e = N'((p * 37 + 11) ^ (p >> 2));
      pulse(N'(p));
      wr(A_ENAB, 32'(e));
      rd(A_STAT, d); check("R3 R4 sweep status", d, 32'(p));
      rd(A_PEND, d); check("R8 sweep pending", d, 32'(N'(p) & e));
      rd(A_VEC, d);  check("R9 sweep vector", d, low_vec(N'(p) & e));
      check("R10 sweep irq_out", {31'b0, irq_out}, {31'b0, |(N'(p) & e)});
      wr(A_ACK, 32'hFF);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule